// File: doc/BRIEF.md
# Two-Wire Slave Byte Memory

This block is a slave on a two-wire serial bus, built around an on-chip array of 512 bytes. It works from the block clock and samples the bus clock and data lines, which it never drives except to pull data low. It finds Start and Stop conditions, shifts bytes in and out MSB first, and answers each byte it accepts by pulling data low during the ninth clock. The byte address is 9 bits. Its top bit, the page, comes in the device-select byte, and the low 8 bits come in the byte that follows.

A write stores each data byte during the acknowledge of that byte. The transfer is therefore finished before the master can start another one, and the block never reports busy. An internal address counter steps once per byte, so sequential writes and reads run across the page boundary and wrap at the end of the array. A repeated Start keeps the counter. A master can therefore set an address and then read from it.

Top module: `twm_slave_mem`

## Requirements
- R1: While reset is held, and after it is released, the block does not pull the data line low (`sda_oe` = 0) and waits for a Start.
- R2: The select byte is sent MSB first as `1010 S1 S0 P D`. S1 and S0 must equal `strap_id[1]` and `strap_id[0]`, P is the page bit, and D is the direction (0 = write, 1 = read). On a match the block pulls data low through the ninth clock.
- R3: A select byte that does not match gets no acknowledge. The block then ignores the bus until the next Start: later bytes get no acknowledge and the memory is unchanged.
- R4: In a write, the byte after the select is the word address. Every later byte is acknowledged and stored at the current 9-bit address.
- R5: After each stored or fetched byte the 9-bit address steps by one and wraps from 0x1FF to 0x000. The step from 0x0FF to 0x100 crosses the page boundary.
- R6: In a read, data bits are placed on the bus only while the clock is low. A master acknowledge fetches the next byte. A master no-acknowledge releases the data line.
- R7: The address is kept across a repeated Start and across a Stop. A read select that follows continues from the stored address.
- R8: A Start or Stop in the middle of a byte abandons that byte. A partly received data byte is not stored, and the data line is released.
- R9: The block has no busy state. A select byte sent straight after a write's Stop is acknowledged.
- R10: The page bit of every matching select byte becomes bit 8 of the address, so the two pages of 256 bytes are separate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the bus |
| rst_n | input | 1 | Active-low reset (power-on) |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Resolved level of the bus data line |
| strap_id | input | 2 | Strap bits compared with select bits S1:S0 |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench attacks the page boundary. It writes two bytes starting at 0x1FF and checks that the second one lands at 0x000. A counter that dropped the carry, or that failed to wrap, would put the second byte elsewhere. It checks that the same word offset holds different bytes on the two pages; a block that ignored the page bit would alias them. It cuts a data byte short with a Stop after four bits, and the old contents must survive; a block that wrote on a bit count instead of on a full byte would corrupt the location. It also sends a select with the wrong strap bits and then a full write. A block that did not lock itself out would acknowledge, or store, the bytes that follow.

// File: rtl/twm_pkg.sv
`timescale 1ns/1ps
package twm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WORD,
      ST_DATA,
      ST_ACK,
      ST_RD,
      ST_RACK
   } twm_state_t;
endpackage

// File: rtl/twm_bus_cond.sv
`timescale 1ns/1ps
module twm_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_s, sda_s, scl_q, sda_q;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad
      $error("twm_bus_cond: SYNC_STAGES must be 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign scl_s = scl_i;
      assign sda_s = sda_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] scl_p, sda_p;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
         end else begin
            scl_p <= (scl_p << 1) | SYNC_STAGES'(scl_i);
            sda_p <= (sda_p << 1) | SYNC_STAGES'(sda_i);
         end
      end
      assign scl_s = scl_p[SYNC_STAGES-1];
      assign sda_s = sda_p[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_lvl   = scl_s;
   assign sda_lvl   = sda_s;
   assign scl_rise  = !scl_q && scl_s;
   assign scl_fall  = scl_q && !scl_s;
   assign start_det = scl_q && scl_s && sda_q && !sda_s;
   assign stop_det  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/twm_mem_array.sv
`timescale 1ns/1ps
module twm_mem_array #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH > 4096) begin : g_bad
      $error("twm_mem_array: array too deep");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/twm_slave_mem.sv
`timescale 1ns/1ps
module twm_slave_mem
   import twm_pkg::*;
#(
   parameter int         ADDR_W      = 9,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_id,
   output logic       sda_oe
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

   if (DATA_W != 8) begin : g_bad_data
      $error("twm_slave_mem: bus byte must be 8 bits");
   end
   if (ADDR_W != DATA_W + 1) begin : g_bad_addr
      $error("twm_slave_mem: address must be one page bit plus a word byte");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   twm_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twm_state_t        state, ret_q;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, rdata;
   logic [ADDR_W-1:0] ptr;
   logic              mack;
   logic              byte_end, sel_match, mem_we, quiet;

   assign quiet     = !start_det && !stop_det;
   assign byte_end  = scl_fall && (cnt == FULL) && quiet;
   assign sel_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:2] == strap_id);
   assign mem_we    = (state == ST_DATA) && byte_end;

   twm_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .we(mem_we), .waddr(ptr), .wdata(shreg),
      .raddr(ptr), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ret_q <= ST_IDLE;
         cnt   <= '0;
         shreg <= '0;
         ptr   <= '0;
         mack  <= 1'b0;
      end else if (start_det) begin
         state <= ST_DEV;
         cnt   <= '0;
      end else if (stop_det) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_DEV, ST_WORD, ST_DATA: begin
               if (scl_rise && cnt < FULL) begin
                  shreg <= {shreg[DATA_W-2:0], sda_lvl};
                  cnt   <= cnt + CNT_W'(1);
               end else if (byte_end) begin
                  state <= ST_ACK;
                  if (state == ST_DEV) begin
                     if (sel_match) begin
                        ptr[ADDR_W-1] <= shreg[1];
                        ret_q         <= shreg[0] ? ST_RD : ST_WORD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_WORD) begin
                     ptr[DATA_W-1:0] <= shreg;
                     ret_q           <= ST_DATA;
                  end else begin
                     ptr   <= ptr + ADDR_W'(1);
                     ret_q <= ST_DATA;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt   <= '0;
                  state <= ret_q;
                  if (ret_q == ST_RD) begin
                     shreg <= rdata;
                     ptr   <= ptr + ADDR_W'(1);
                  end
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  cnt <= cnt + CNT_W'(1);
               end else if (scl_fall) begin
                  if (cnt == FULL) state <= ST_RACK;
                  else             shreg <= {shreg[DATA_W-2:0], 1'b0};
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack <= !sda_lvl;
               end else if (scl_fall) begin
                  if (mack) begin
                     shreg <= rdata;
                     ptr   <= ptr + ADDR_W'(1);
                     cnt   <= '0;
                     state <= ST_RD;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe = (state == ST_ACK) || (state == ST_RD && !shreg[DATA_W-1]);

   // R4
   write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> sda_oe);
   // R3
   nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV && byte_end && !sel_match) |=> !sda_oe);
   // R6
   sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);
   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
   // R9
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_DEV));
   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && ptr == '1) |=> (ptr == '0));
endmodule

// File: tb/tb_twm_slave_mem.sv
`timescale 1ns/1ps
module tb_twm_slave_mem;
   logic       clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] strap = 2'b10;
   logic       sda_oe;
   wire        sda_line = sda_m & ~sda_oe;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;
   localparam int Q = 8;

   twm_slave_mem dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .strap_id(strap), .sda_oe(sda_oe)
   );

   always #10 clk = ~clk;

   // {page, word, data}
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 8'h00, 8'h5A}, {1'b0, 8'h10, 8'hC3}, {1'b1, 8'h00, 8'hA5},
      {1'b1, 8'h7F, 8'h3C}, {1'b0, 8'hFE, 8'h81}, {1'b1, 8'h80, 8'h7E}
   };

   task automatic wq(); repeat (Q) @(negedge clk); endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
      bit_xfer(1'b1, r);
      ack = !r;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, r);
         d[i] = r;
      end
      bit_xfer(!give_ack, r);
   endtask

   function automatic logic [7:0] sel(input logic pg, input logic rd);
      return {4'b1010, strap, pg, rd};
   endfunction

   task automatic write_one(input logic pg, input logic [7:0] w, input logic [7:0] d,
                            output logic ok);
      logic a0, a1, a2;
      bus_start();
      send_byte(sel(pg, 1'b0), a0);
      send_byte(w, a1);
      send_byte(d, a2);
      bus_stop();
      ok = a0 & a1 & a2;
   endtask

   task automatic rand_read(input logic pg, input logic [7:0] w, output logic [7:0] d,
                            output logic ok);
      logic a0, a1, a2;
      bus_start();
      send_byte(sel(pg, 1'b0), a0);
      send_byte(w, a1);
      bus_start();
      send_byte(sel(pg, 1'b1), a2);
      recv_byte(1'b0, d);
      bus_stop();
      ok = a0 & a1 & a2;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic       ok, a0, a1, a2, a3;
      logic [7:0] d, d2;
      repeat (5) @(negedge clk);
      chk("R1 released in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      wq();
      chk("R1 released after reset", int'(sda_oe), 0);

      // R2 R4 R9: table-driven writes, each back to back
      for (int i = 0; i < 6; i++) begin
         write_one(VEC[i][16], VEC[i][15:8], VEC[i][7:0], ok);
         chk("R2 R4 R9 write acks", int'(ok), 1);
      end
      // R7 R10: random reads of every vector
      for (int i = 0; i < 6; i++) begin
         rand_read(VEC[i][16], VEC[i][15:8], d, ok);
         chk("R7 random read acks", int'(ok), 1);
         chk("R10 R4 read data", int'(d), int'(VEC[i][7:0]));
      end

      // R3: wrong strap bits, then a full write that must be ignored
      bus_start();
      send_byte({4'b1010, ~strap, 1'b0, 1'b0}, a0);
      send_byte(8'h10, a1);
      send_byte(8'hEE, a2);
      bus_stop();
      chk("R3 no ack on mismatch", int'(a0), 0);
      chk("R3 no ack after mismatch", int'(a1 | a2), 0);
      rand_read(1'b0, 8'h10, d, ok);
      chk("R3 memory unchanged", int'(d), 8'hC3);

      // R5: sequential write across the end of the array
      bus_start();
      send_byte(sel(1'b1, 1'b0), a0);
      send_byte(8'hFF, a1);
      send_byte(8'h11, a2);
      send_byte(8'h22, a3);
      bus_stop();
      chk("R5 wrap write acks", int'(a0 & a1 & a2 & a3), 1);
      // R9: select straight after the write's stop
      bus_start();
      send_byte(sel(1'b0, 1'b0), a0);
      bus_stop();
      chk("R9 immediate select ack", int'(a0), 1);
      rand_read(1'b0, 8'h00, d, ok);
      chk("R5 wrapped byte at 0x000", int'(d), 8'h22);

      // R6: sequential read across the wrap, ack then nack
      bus_start();
      send_byte(sel(1'b1, 1'b0), a0);
      send_byte(8'hFF, a1);
      bus_start();
      send_byte(sel(1'b1, 1'b1), a2);
      recv_byte(1'b1, d);
      recv_byte(1'b0, d2);
      chk("R6 released after nack", int'(sda_oe), 0);
      bus_stop();
      chk("R6 first read byte", int'(d), 8'h11);
      chk("R5 R6 second read byte", int'(d2), 8'h22);

      // R5: page crossing 0x0FF -> 0x100
      bus_start();
      send_byte(sel(1'b0, 1'b0), a0);
      send_byte(8'hFF, a1);
      send_byte(8'h44, a2);
      send_byte(8'h55, a3);
      bus_stop();
      rand_read(1'b1, 8'h00, d, ok);
      chk("R5 page crossing", int'(d), 8'h55);

      // R7: current-address read after a stop
      bus_start();
      send_byte(sel(1'b1, 1'b0), a0);
      send_byte(8'h50, a1);
      send_byte(8'h01, a2);
      send_byte(8'h02, a3);
      bus_stop();
      rand_read(1'b1, 8'h50, d, ok);
      chk("R7 random read", int'(d), 8'h01);
      bus_start();
      send_byte(sel(1'b1, 1'b1), a0);
      recv_byte(1'b0, d);
      bus_stop();
      chk("R7 current read ack", int'(a0), 1);
      chk("R7 current read data", int'(d), 8'h02);

      // R8: stop after four data bits
      bus_start();
      send_byte(sel(1'b0, 1'b0), a0);
      send_byte(8'h10, a1);
      for (int i = 0; i < 4; i++) bit_xfer(1'b1, a2);
      bus_stop();
      chk("R8 released after abort", int'(sda_oe), 0);
      rand_read(1'b0, 8'h10, d, ok);
      chk("R8 partial byte not stored", int'(d), 8'hC3);

      summary();
      done = 1'b1;
      $finish;
   end
endmodule